// File: doc/BRIEF.md
# Monitor Slot Byte Handshake Controller

This block moves single bytes through a monitor time slot that recurs once per frame of a time-division link. Each direction has a byte field and a one-bit handshake. The sender raises its transmit-handshake bit while it presents a byte. The receiver raises its acknowledge bit once it trusts the byte. A processor loads outgoing bytes through a write strobe and picks up incoming bytes from a receive register. It learns what happened from five sticky status flags, which are cleared by a read strobe.

The line side is sampled only on a frame-sync pulse, once per frame. Between pulses the line-facing state holds. A byte is trusted only if the same value arrives in two frames in a row with the handshake bit active. If the second copy differs, the block sends an abort toward the far transmitter for one frame. It also records a local-abort flag. After at least one byte has been accepted, a far-end handshake bit that stays inactive for two frames marks the end of a message. A command input clears both directions and all flags at once.

Top module: `mon_hs_ctrl`

## Requirements
- R1: After rst_n is low, all outputs are zero: tx_byte_o, tx_mx_o, tx_mr_o, tx_abort_o, rx_data_o and status_o. The status_o bits are: bit4 end of message, bit3 local abort, bit2 receive byte ready, bit1 remote abort, bit0 transmit register free.
- R2: Line inputs (rx_byte_i, rx_mx_i, rx_mr_i, rx_abort_i) are acted on only in a clock cycle where frame_sync_i is high. In any other cycle they have no effect on any output.
- R3: If rx_mx_i is high at two consecutive frame pulses with the same rx_byte_i both times, that byte is loaded into rx_data_o and status bit2 is set. Both take effect on the clock edge of the second pulse.
- R4: The acceptance case can fail when rx_mx_i is high at the second pulse but rx_byte_i differs from the first copy. In that case rx_data_o is unchanged, tx_abort_o goes high until the next frame pulse, and status bit3 is set. Reception then restarts from the idle state.
- R5: tx_mr_o is high from the accepting pulse until the first frame pulse at which rx_mx_i is low.
- R6: A wr_en_i while the transmitter is free loads wr_data_i into tx_byte_o and raises tx_mx_o on the next edge. A wr_en_i while tx_mx_o is high is ignored.
- R7: A frame pulse with rx_mr_i high while tx_mx_o is high lowers tx_mx_o and sets status bit0.
- R8: A frame pulse with rx_abort_i high while tx_mx_o is high lowers tx_mx_o and sets status bits 1 and 0. At this pulse, rx_abort_i takes precedence over rx_mr_i.
- R9: After a byte has been accepted, two consecutive frame pulses with rx_mx_i low set status bit4. Counting then stops until another byte is accepted.
- R10: Status bits are sticky. A cycle with rd_stat_i high clears them on that edge, except that a bit set by an event in the same cycle stays set.
- R11: cmd_reset_i high clears all state in both directions and all status bits on that edge. It takes precedence over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync_i | input | 1 | One-cycle pulse marking the monitor slot of each frame |
| rx_byte_i | input | DATA_W | Byte received in the monitor slot |
| rx_mx_i | input | 1 | Far-end transmit-handshake bit |
| rx_mr_i | input | 1 | Far-end acknowledge bit |
| rx_abort_i | input | 1 | Far-end abort indication |
| wr_en_i | input | 1 | Processor write strobe for an outgoing byte |
| wr_data_i | input | DATA_W | Outgoing byte |
| rd_stat_i | input | 1 | Processor status read; clears the flags |
| cmd_reset_i | input | 1 | Synchronous clear of both directions |
| tx_byte_o | output | DATA_W | Byte driven into the monitor slot |
| tx_mx_o | output | 1 | Local transmit-handshake bit |
| tx_mr_o | output | 1 | Local acknowledge bit |
| tx_abort_o | output | 1 | Abort sent to the far transmitter |
| rx_data_o | output | DATA_W | Last accepted byte |
| status_o | output | 5 | Sticky flags, layout in R1 |

## Verification
The bench aims at the confirmation window. It sends a mismatched second copy and checks that no byte is accepted and that an abort is raised. A design that compared against the wrong frame would accept the garbled byte or abort on a good one. The bench also wiggles line inputs between frame pulses, where a design that samples on every clock would change state. It overlaps status reads with flag-setting events, where a wrong priority would lose a flag. It issues a write while busy, where a design without the guard would overwrite the byte in flight. It also sends a far-end abort together with an acknowledge, and issues a reset in the middle of a transfer.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;
  localparam int FLAG_W = 5;
  localparam int F_XMR = 0;  // transmit register free
  localparam int F_RAB = 1;  // remote abort seen
  localparam int F_RMR = 2;  // receive byte ready
  localparam int F_XAB = 3;  // local abort issued
  localparam int F_EOM = 4;  // end of message

  typedef enum logic [1:0] {RX_WAIT, RX_HELD, RX_ACKING} rx_st_e;
  typedef enum logic {TX_FREE, TX_BUSY} tx_st_e;

  // next value of the idle-frame counter, saturating at the limit
  function automatic int unsigned idle_next(input int unsigned cnt, input logic mx,
                                            input int unsigned limit);
    if (mx) return 0;
    if (cnt >= limit) return limit;
    return cnt + 1;
  endfunction
endpackage

// File: rtl/mon_rx_ctl.sv
module mon_rx_ctl
  import mon_hs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int EOM_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              sync_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              mx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ack_o,
  output logic              abort_o,
  output logic              acc_evt_o,
  output logic              mis_evt_o,
  output logic              eom_evt_o
);
  localparam int CNT_W = $clog2(EOM_FRAMES + 1);

  rx_st_e            st_q;
  logic [DATA_W-1:0] cand_q;
  logic              started_q;
  logic [CNT_W-1:0]  idle_q;
  logic [CNT_W-1:0]  idle_d;

  assign acc_evt_o = sync_i && (st_q == RX_HELD) && mx_i && (byte_i == cand_q);
  assign mis_evt_o = sync_i && (st_q == RX_HELD) && mx_i && (byte_i != cand_q);
  assign idle_d    = CNT_W'(idle_next(int'(idle_q), mx_i, EOM_FRAMES));
  assign eom_evt_o = sync_i && started_q && !mx_i && (int'(idle_d) == EOM_FRAMES);
  assign ack_o     = (st_q == RX_ACKING);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= RX_WAIT;
      cand_q    <= '0;
      data_o    <= '0;
      abort_o   <= 1'b0;
      started_q <= 1'b0;
      idle_q    <= '0;
    end else if (clr_i) begin
      st_q      <= RX_WAIT;
      cand_q    <= '0;
      data_o    <= '0;
      abort_o   <= 1'b0;
      started_q <= 1'b0;
      idle_q    <= '0;
    end else if (sync_i) begin
      abort_o <= mis_evt_o;
      unique case (st_q)
        RX_WAIT: if (mx_i) begin
          cand_q <= byte_i;
          st_q   <= RX_HELD;
        end
        RX_HELD: begin
          if (acc_evt_o) begin
            data_o <= byte_i;
            st_q   <= RX_ACKING;
          end else begin
            st_q <= RX_WAIT;
          end
        end
        RX_ACKING: if (!mx_i) st_q <= RX_WAIT;
        default: st_q <= RX_WAIT;
      endcase
      if (acc_evt_o) begin
        started_q <= 1'b1;
        idle_q    <= '0;
      end else if (eom_evt_o) begin
        started_q <= 1'b0;
        idle_q    <= '0;
      end else if (started_q) begin
        idle_q <= idle_d;
      end
    end
  end
endmodule

// File: rtl/mon_tx_ctl.sv
module mon_tx_ctl
  import mon_hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              sync_i,
  input  logic              mr_i,
  input  logic              abort_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              mx_o,
  output logic              done_evt_o,
  output logic              rab_evt_o
);
  tx_st_e st_q;

  assign rab_evt_o  = sync_i && (st_q == TX_BUSY) && abort_i;
  assign done_evt_o = sync_i && (st_q == TX_BUSY) && (abort_i || mr_i);
  assign mx_o       = (st_q == TX_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_FREE;
      byte_o <= '0;
    end else if (clr_i) begin
      st_q   <= TX_FREE;
      byte_o <= '0;
    end else if (st_q == TX_BUSY) begin
      if (done_evt_o) st_q <= TX_FREE;
    end else if (wr_i) begin
      byte_o <= wdata_i;
      st_q   <= TX_BUSY;
    end
  end
endmodule

// File: rtl/mon_flags.sv
module mon_flags #(
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              rd_i,
  input  logic [FLAG_W-1:0] set_i,
  output logic [FLAG_W-1:0] flags_o
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_o[i] <= 1'b0;
      else if (clr_i)      flags_o[i] <= 1'b0;
      else if (set_i[i])   flags_o[i] <= 1'b1;
      else if (rd_i)       flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_hs_ctrl.sv
module mon_hs_ctrl
  import mon_hs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int EOM_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_mx_i,
  input  logic              rx_mr_i,
  input  logic              rx_abort_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_stat_i,
  input  logic              cmd_reset_i,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              tx_mx_o,
  output logic              tx_mr_o,
  output logic              tx_abort_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [4:0]        status_o
);
  logic acc_evt, mis_evt, eom_evt, done_evt, rab_evt;
  logic [FLAG_W-1:0] set_vec;

  mon_rx_ctl #(.DATA_W(DATA_W), .EOM_FRAMES(EOM_FRAMES)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr_i(cmd_reset_i), .sync_i(frame_sync_i),
    .byte_i(rx_byte_i), .mx_i(rx_mx_i), .data_o(rx_data_o), .ack_o(tx_mr_o),
    .abort_o(tx_abort_o), .acc_evt_o(acc_evt), .mis_evt_o(mis_evt),
    .eom_evt_o(eom_evt)
  );

  mon_tx_ctl #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr_i(cmd_reset_i), .sync_i(frame_sync_i),
    .mr_i(rx_mr_i), .abort_i(rx_abort_i), .wr_i(wr_en_i), .wdata_i(wr_data_i),
    .byte_o(tx_byte_o), .mx_o(tx_mx_o), .done_evt_o(done_evt),
    .rab_evt_o(rab_evt)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[F_XMR] = done_evt;
    set_vec[F_RAB] = rab_evt;
    set_vec[F_RMR] = acc_evt;
    set_vec[F_XAB] = mis_evt;
    set_vec[F_EOM] = eom_evt;
  end

  mon_flags #(.FLAG_W(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr_i(cmd_reset_i), .rd_i(rd_stat_i),
    .set_i(set_vec), .flags_o(status_o)
  );
endmodule

// File: rtl/mon_hs_chk.sv
module mon_hs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_sync_i,
  input logic              cmd_reset_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] tx_byte_o,
  input logic              tx_mx_o,
  input logic              tx_mr_o,
  input logic              tx_abort_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic [4:0]        status_o
);
  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync_i && !cmd_reset_i) |=> ($stable(tx_mr_o) && $stable(tx_abort_o) && $stable(rx_data_o)));
  // R3
  accept_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_mr_o) |-> status_o[2]);
  // R4
  abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_abort_o) |-> status_o[3]);
  // R6
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mx_o && wr_en_i && !cmd_reset_i) |=> $stable(tx_byte_o));
  // R7
  free_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_mx_o) && !$past(cmd_reset_i)) |-> status_o[0]);
  // R11
  cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset_i |=> (!tx_mx_o && !tx_mr_o && !tx_abort_o && status_o == 5'd0));
endmodule

bind mon_hs_ctrl mon_hs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync_i(frame_sync_i), .cmd_reset_i(cmd_reset_i),
  .wr_en_i(wr_en_i), .tx_byte_o(tx_byte_o), .tx_mx_o(tx_mx_o), .tx_mr_o(tx_mr_o),
  .tx_abort_o(tx_abort_o), .rx_data_o(rx_data_o), .status_o(status_o)
);

// File: tb/mon_hs_ctrl_tb_top.sv
module mon_hs_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic fs = 0, mx = 0, mr = 0, ab = 0, wr = 0, rd = 0, cr = 0;
  logic [7:0] rxb = 0, wd = 0;
  logic [7:0] tx_byte, rx_data;
  logic tx_mx, tx_mr, tx_ab;
  logic [4:0] st;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mon_hs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .frame_sync_i(fs), .rx_byte_i(rxb), .rx_mx_i(mx),
    .rx_mr_i(mr), .rx_abort_i(ab), .wr_en_i(wr), .wr_data_i(wd), .rd_stat_i(rd),
    .cmd_reset_i(cr), .tx_byte_o(tx_byte), .tx_mx_o(tx_mx), .tx_mr_o(tx_mr),
    .tx_abort_o(tx_ab), .rx_data_o(rx_data), .status_o(st)
  );

  // behavioural reference
  int m_rxs = 0, m_cand = 0, m_rxd = 0, m_abo = 0, m_started = 0, m_idle = 0;
  int m_busy = 0, m_txb = 0, m_flags = 0;

  always @(posedge clk) begin
    int ev;
    ev = 0;
    if (!rst_n || cr) begin
      m_rxs = 0; m_cand = 0; m_rxd = 0; m_abo = 0; m_started = 0; m_idle = 0;
      m_busy = 0; m_txb = 0; m_flags = 0;
    end else begin
      if (m_busy != 0) begin
        if (fs && ab) begin ev |= 3; m_busy = 0; end
        else if (fs && mr) begin ev |= 1; m_busy = 0; end
      end else if (wr) begin
        m_txb = wd; m_busy = 1;
      end
      if (fs) begin
        m_abo = 0;
        if (m_rxs == 1 && mx && rxb == m_cand) begin
          m_rxd = rxb; m_rxs = 2; ev |= 4; m_started = 1; m_idle = 0;
        end else begin
          if (m_rxs == 1 && mx) begin m_abo = 1; ev |= 8; m_rxs = 0; end
          else if (m_rxs == 1) m_rxs = 0;
          else if (m_rxs == 0 && mx) begin m_cand = rxb; m_rxs = 1; end
          else if (m_rxs == 2 && !mx) m_rxs = 0;
          if (m_started != 0) begin
            if (mx) m_idle = 0;
            else begin
              m_idle++;
              if (m_idle == 2) begin ev |= 16; m_started = 0; m_idle = 0; end
            end
          end
        end
      end
      m_flags = (rd ? 0 : m_flags) | ev;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R3 rx_data", rx_data, m_rxd);
      check("R5 tx_mr", tx_mr, (m_rxs == 2) ? 1 : 0);
      check("R4 tx_abort", tx_ab, m_abo);
      check("R6 tx_mx", tx_mx, m_busy);
      check("R6 tx_byte", tx_byte, m_txb);
      check("R10 status", st, m_flags);
    end
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic frame(input logic [7:0] b, input logic m, input logic r,
                       input logic a, input logic rdx);
    @(negedge clk); rxb = b; mx = m; mr = r; ab = a; rd = rdx; fs = 1;
    @(negedge clk); fs = 0; rd = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rdst();
    @(negedge clk); rd = 1; @(negedge clk); rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 status", st, 0); check("R1 mx", tx_mx, 0); check("R1 rx_data", rx_data, 0);
    rst_n = 1;
    // R3 accept
    frame(8'hA5, 1, 0, 0, 0);
    check("R3 no early accept", rx_data, 0);
    frame(8'hA5, 1, 0, 0, 0);
    check("R3 accepted", rx_data, 8'hA5); check("R3 flag", st[2], 1);
    check("R5 ack high", tx_mr, 1);
    // R2: wiggle line without sync
    @(negedge clk); mx = 0; rxb = 8'h11; ab = 1; mr = 1;
    repeat (4) @(negedge clk);
    check("R2 ack held", tx_mr, 1); ab = 0; mr = 0;
    rdst(); check("R10 cleared", st, 0);
    frame(8'h00, 0, 0, 0, 0);
    check("R5 ack dropped", tx_mr, 0); check("R9 not yet", st[4], 0);
    frame(8'h00, 0, 0, 0, 0);
    check("R9 eom", st[4], 1);
    frame(8'h00, 0, 0, 0, 0); frame(8'h00, 0, 0, 0, 0);
    rdst();
    // R4 mismatch
    frame(8'h3C, 1, 0, 0, 0);
    frame(8'h3D, 1, 0, 0, 0);
    check("R4 abort", tx_ab, 1); check("R4 data kept", rx_data, 8'hA5);
    check("R4 flag", st[3], 1);
    frame(8'h3D, 0, 0, 0, 0);
    check("R4 abort one frame", tx_ab, 0);
    rdst();
    // R6 / R7 transmit
    @(negedge clk); wr = 1; wd = 8'h5A; @(negedge clk); wr = 0;
    check("R6 byte", tx_byte, 8'h5A); check("R6 mx", tx_mx, 1);
    @(negedge clk); wr = 1; wd = 8'h77; @(negedge clk); wr = 0;
    check("R6 busy ignore", tx_byte, 8'h5A);
    frame(8'h00, 0, 1, 0, 0);
    check("R7 mx low", tx_mx, 0); check("R7 free flag", st, 5'b00001);
    rdst();
    // R8 remote abort with ack, R10 read collides with set
    @(negedge clk); wr = 1; wd = 8'hC3; @(negedge clk); wr = 0;
    frame(8'h00, 0, 1, 1, 1);
    check("R8 mx low", tx_mx, 0); check("R8 flags", st, 5'b00011);
    check("R10 set beats read", st[1], 1);
    rdst();
    // R11 command reset mid transfer
    @(negedge clk); wr = 1; wd = 8'h99; @(negedge clk); wr = 0;
    frame(8'h42, 1, 0, 0, 0); frame(8'h42, 1, 0, 0, 0);
    @(negedge clk); cr = 1; @(negedge clk); cr = 0;
    check("R11 mx", tx_mx, 0); check("R11 mr", tx_mr, 0);
    check("R11 status", st, 0); check("R11 rx_data", rx_data, 0);
    frame(8'h00, 0, 0, 0, 0); frame(8'h00, 0, 0, 0, 0);
    check("R11 no eom after clear", st[4], 0);
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule